// File: doc/BRIEF.md
# Receive Header-Split Parser

This block sits on the receive path of a network interface. It takes one Ethernet frame at a time as a byte stream and decides where the protocol headers end and the application payload begins. The frame is written into a local frame store while it arrives. An online parser picks the fields it needs out of the passing bytes. Once the last byte is in, the split offset is chosen. The stored frame is then replayed as two write streams: one for a header buffer and one for a data buffer. Each stream is padded with zero bytes up to a whole cache line, so the host never sees a partial line store that would force a read-modify-write.

Only plain TCP carried directly in IPv4 or IPv6 is recognised. Any other layout gives a fallback split at a host-programmed fixed offset. This includes tunnels, other transports, malformed lengths and frames that end too early. A fixed-offset mode skips parsing altogether. A typical host setting for that offset is 86 bytes: 14 for Ethernet, 40 for IPv6, 20 for TCP and 12 for the timestamp option. While a frame is being replayed, the block holds its input ready low.

Top module: `rx_hdr_split`

## Requirements
- R1: A frame begins with a byte marked `in_sof` and ends with a byte marked `in_eof`; a byte is taken when `in_valid` and `in_ready` are both high; bytes offered without `in_sof` while no frame is open are ignored; `in_ready` is low from the cycle after the end byte is taken until both write streams have finished.
- R2: Ethertype 0x0800 (byte 12 high, byte 13 low) with a version nibble of 4 in the high half of byte 14, a header-length nibble of at least 5 in its low half, and a protocol byte 23 equal to 6 places the TCP header at 14 + 4 × header-length nibble.
- R3: Ethertype 0x86DD with a version nibble of 6 in the high half of byte 14 and a next-header byte 20 equal to 6 places the TCP header at byte 54.
- R4: The TCP data offset is the high nibble of the byte 12 bytes into the TCP header; the parsed split is the TCP start plus 4 × that nibble, and a nibble below 5 is a parse failure.
- R5: When parsing fails, the split is the latched fixed offset and `res_parsed` is 0. Failures are: any other ethertype or version, a protocol other than 6, a data offset below 5, a frame that ends before the data-offset byte, or a frame shorter than the parsed split.
- R6: With `cfg_fixed_only` set, the split is always the fixed offset and `res_parsed` is 0, even for a valid TCP frame.
- R7: The header stream carries frame bytes 0 to H−1 in order, where H is the smaller of the split and the frame length. It then carries zero bytes with `hdr_pad` set until the count is a multiple of 64. `hdr_last` marks the final beat, and there are no beats when H is 0.
- R8: The payload stream carries frame bytes H to the end in order. It then carries zero bytes with `pay_pad` set up to a multiple of 64. `pay_last` marks the final beat, and there are no beats when the payload is empty.
- R9: If the frame is shorter than the chosen split, the whole frame goes to the header stream and `res_pay_len` is 0.
- R10: Exactly one single-cycle `res_valid` pulse is produced per frame, before any write beat of that frame. It carries the chosen split, the payload length and the parse flag.
- R11: The configuration inputs are sampled with the start byte; changing them later in the frame has no effect on that frame.
- R12: All header beats of a frame come before its first payload beat, and the two streams are never valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fixed_only | input | 1 | Skip parsing and always split at the fixed offset |
| cfg_fixed_off | input | $clog2(FRAME_DEPTH+1) | Fixed split offset in bytes |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take a byte |
| hdr_valid | output | 1 | Header-buffer write beat |
| hdr_data | output | 8 | Header-buffer byte |
| hdr_pad | output | 1 | Header beat is zero padding |
| hdr_last | output | 1 | Final header beat of the frame |
| pay_valid | output | 1 | Data-buffer write beat |
| pay_data | output | 8 | Data-buffer byte |
| pay_pad | output | 1 | Data beat is zero padding |
| pay_last | output | 1 | Final data beat of the frame |
| res_valid | output | 1 | Per-frame result pulse |
| res_parsed | output | 1 | Split came from TCP/IP parsing |
| res_split | output | $clog2(FRAME_DEPTH+1) | Chosen split offset |
| res_pay_len | output | $clog2(FRAME_DEPTH+1) | Payload length in bytes, padding excluded |

## Verification
The bench builds the block with FRAME_DEPTH = 256 and the default 64-byte line. This keeps replay short, so many frames fit in one run. The 9-bit offset field can still name splits beyond any frame sent, which reaches the short-frame rule. Frames range from a single byte up to the deepest legal split of 134 bytes plus payload. This covers the 54, 86 and 134-byte parsed splits, a split of exactly one line, a zero fixed offset that empties the header stream, and frames that end inside the TCP header.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int unsigned ETH_HDR_LEN   = 14;
    localparam int unsigned OFS_ETYPE_HI  = 12;
    localparam int unsigned OFS_ETYPE_LO  = 13;
    localparam int unsigned OFS_VERSION   = 14;
    localparam int unsigned OFS_V6_NEXT   = 20;
    localparam int unsigned OFS_V4_PROTO  = 23;
    localparam int unsigned IPV6_HDR_LEN  = 40;
    localparam int unsigned TCP_DOFF_REL  = 12;
    localparam int unsigned TCP_MIN_WORDS = 5;
    localparam int unsigned SPLIT_MIN     = 54;
    localparam int unsigned SPLIT_MAX     = 134;

    localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
    localparam logic [15:0] ETYPE_IPV6 = 16'h86DD;
    localparam logic [7:0]  PROTO_TCP  = 8'd6;

    typedef enum logic [1:0] {
        T_IDLE,
        T_RECV,
        T_DECIDE,
        T_EMIT
    } top_state_e;

    typedef enum logic [1:0] {
        E_IDLE,
        E_HDR,
        E_PAY
    } emit_phase_e;

    typedef struct packed {
        logic       valid;
        logic       last;
        logic       pad;
        logic [7:0] data;
    } wr_beat_t;

endpackage

// File: rtl/hs_proto_parser.sv
module hs_proto_parser
    import hs_pkg::*;
#(
    parameter int unsigned IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  logic             sof,
    input  logic [7:0]       data,
    input  logic             cfg_fixed_only,
    input  logic [IDX_W-1:0] cfg_fixed_off,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] frm_len,
    output logic [IDX_W-1:0] dec_split,
    output logic             dec_parsed
);

    logic [IDX_W-1:0] cnt;
    logic [7:0]       et_hi, et_lo, ver_ihl, v6_next, v4_proto;
    logic [3:0]       doff_q;
    logic             have_doff;
    logic             fixed_only_q;
    logic [IDX_W-1:0] fixed_off_q;

    logic [15:0]      etype;
    logic             tcp_v4, tcp_v6, hdr_ok;
    logic [IDX_W-1:0] tcp_start, doff_idx, tcp_split;

    assign cur_idx = sof ? '0 : cnt;
    assign etype   = {et_hi, et_lo};

    // IP layer recognition from captured bytes
    assign tcp_v4 = (etype == ETYPE_IPV4) && (ver_ihl[7:4] == 4'd4) &&
                    (ver_ihl[3:0] >= 4'(TCP_MIN_WORDS)) && (v4_proto == PROTO_TCP);
    assign tcp_v6 = (etype == ETYPE_IPV6) && (ver_ihl[7:4] == 4'd6) &&
                    (v6_next == PROTO_TCP);

    always_comb begin
        if (etype == ETYPE_IPV4)
            tcp_start = IDX_W'(ETH_HDR_LEN) + IDX_W'({ver_ihl[3:0], 2'b00});
        else
            tcp_start = IDX_W'(ETH_HDR_LEN + IPV6_HDR_LEN);
    end

    assign doff_idx  = tcp_start + IDX_W'(TCP_DOFF_REL);
    assign tcp_split = tcp_start + IDX_W'({doff_q, 2'b00});

    assign hdr_ok = !fixed_only_q && (tcp_v4 || tcp_v6) && have_doff &&
                    (doff_q >= 4'(TCP_MIN_WORDS)) && (tcp_split <= cnt);

    assign dec_split  = hdr_ok ? tcp_split : fixed_off_q;
    assign dec_parsed = hdr_ok;
    assign frm_len    = cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            et_hi        <= '0;
            et_lo        <= '0;
            ver_ihl      <= '0;
            v6_next      <= '0;
            v4_proto     <= '0;
            doff_q       <= '0;
            have_doff    <= 1'b0;
            fixed_only_q <= 1'b0;
            fixed_off_q  <= '0;
        end else if (acc) begin
            cnt <= cur_idx + IDX_W'(1);
            if (sof) begin
                have_doff    <= 1'b0;
                fixed_only_q <= cfg_fixed_only;
                fixed_off_q  <= cfg_fixed_off;
            end
            if (cur_idx == IDX_W'(OFS_ETYPE_HI)) et_hi    <= data;
            if (cur_idx == IDX_W'(OFS_ETYPE_LO)) et_lo    <= data;
            if (cur_idx == IDX_W'(OFS_VERSION))  ver_ihl  <= data;
            if (cur_idx == IDX_W'(OFS_V6_NEXT))  v6_next  <= data;
            if (cur_idx == IDX_W'(OFS_V4_PROTO)) v4_proto <= data;
            if (!sof && cur_idx == doff_idx) begin
                doff_q    <= data[7:4];
                have_doff <= 1'b1;
            end
        end
    end

    AST_PARSED_SPLIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        dec_parsed |-> (dec_split >= IDX_W'(SPLIT_MIN) && dec_split <= IDX_W'(SPLIT_MAX))); // R4

    AST_PARSED_WITHIN_FRAME: assert property (@(posedge clk) disable iff (rst)
        dec_parsed |-> (dec_split <= frm_len)); // R5

endmodule

// File: rtl/hs_frame_store.sv
module hs_frame_store #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hs_line_emitter.sv
module hs_line_emitter
    import hs_pkg::*;
#(
    parameter int unsigned IDX_W      = 12,
    parameter int unsigned AW         = 11,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] hdr_len,
    input  logic [IDX_W-1:0] pay_len,
    output logic [AW-1:0]    rd_addr,
    input  logic [7:0]       rd_data,
    output wr_beat_t         hdr_beat,
    output wr_beat_t         pay_beat,
    output logic             busy
);

    localparam int unsigned CW = IDX_W + 1;

    function automatic logic [CW-1:0] to_lines(input logic [IDX_W-1:0] n);
        return (CW'(n) + CW'(LINE_BYTES - 1)) & ~CW'(LINE_BYTES - 1);
    endfunction

    emit_phase_e      phase;
    logic [CW-1:0]    pos;
    logic [IDX_W-1:0] hlen_q, plen_q;
    logic [CW-1:0]    htot_q, ptot_q;
    logic [CW-1:0]    htot_in, ptot_in;
    logic             in_body, at_end;

    assign htot_in = to_lines(hdr_len);
    assign ptot_in = to_lines(pay_len);

    always_comb begin
        if (phase == E_PAY) begin
            rd_addr = AW'(CW'(hlen_q) + pos);
            in_body = pos < CW'(plen_q);
            at_end  = pos == ptot_q - CW'(1);
        end else begin
            rd_addr = AW'(pos);
            in_body = pos < CW'(hlen_q);
            at_end  = pos == htot_q - CW'(1);
        end
    end

    assign busy = (phase != E_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= E_IDLE;
            pos      <= '0;
            hlen_q   <= '0;
            plen_q   <= '0;
            htot_q   <= '0;
            ptot_q   <= '0;
            hdr_beat <= '0;
            pay_beat <= '0;
        end else begin
            hdr_beat <= '0;
            pay_beat <= '0;
            case (phase)
                E_IDLE: begin
                    if (start) begin
                        hlen_q <= hdr_len;
                        plen_q <= pay_len;
                        htot_q <= htot_in;
                        ptot_q <= ptot_in;
                        pos    <= '0;
                        if (htot_in != '0)      phase <= E_HDR;
                        else if (ptot_in != '0) phase <= E_PAY;
                    end
                end
                E_HDR: begin
                    hdr_beat.valid <= 1'b1;
                    hdr_beat.data  <= in_body ? rd_data : 8'h00;
                    hdr_beat.pad   <= !in_body;
                    hdr_beat.last  <= at_end;
                    if (at_end) begin
                        pos   <= '0;
                        phase <= (ptot_q != '0) ? E_PAY : E_IDLE;
                    end else begin
                        pos <= pos + CW'(1);
                    end
                end
                E_PAY: begin
                    pay_beat.valid <= 1'b1;
                    pay_beat.data  <= in_body ? rd_data : 8'h00;
                    pay_beat.pad   <= !in_body;
                    pay_beat.last  <= at_end;
                    if (at_end) begin
                        pos   <= '0;
                        phase <= E_IDLE;
                    end else begin
                        pos <= pos + CW'(1);
                    end
                end
                default: phase <= E_IDLE;
            endcase
        end
    end

    AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(hdr_beat.valid && pay_beat.valid)); // R12

    AST_HDR_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hdr_beat.valid && hdr_beat.pad) |-> (hdr_beat.data == 8'h00)); // R7

    AST_PAY_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (pay_beat.valid && pay_beat.pad) |-> (pay_beat.data == 8'h00)); // R8

    AST_HDR_PAD_TAIL: assert property (@(posedge clk) disable iff (rst)
        (hdr_beat.valid && hdr_beat.pad && !hdr_beat.last) |=> (hdr_beat.valid && hdr_beat.pad)); // R7

    AST_PAY_PAD_TAIL: assert property (@(posedge clk) disable iff (rst)
        (pay_beat.valid && pay_beat.pad && !pay_beat.last) |=> (pay_beat.valid && pay_beat.pad)); // R8

endmodule

// File: rtl/rx_hdr_split.sv
module rx_hdr_split
    import hs_pkg::*;
#(
    parameter int unsigned FRAME_DEPTH = 2048,
    parameter int unsigned LINE_BYTES  = 64
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_fixed_only,
    input  logic [$clog2(FRAME_DEPTH+1)-1:0]   cfg_fixed_off,
    input  logic                               in_valid,
    input  logic                               in_sof,
    input  logic                               in_eof,
    input  logic [7:0]                         in_data,
    output logic                               in_ready,
    output logic                               hdr_valid,
    output logic [7:0]                         hdr_data,
    output logic                               hdr_pad,
    output logic                               hdr_last,
    output logic                               pay_valid,
    output logic [7:0]                         pay_data,
    output logic                               pay_pad,
    output logic                               pay_last,
    output logic                               res_valid,
    output logic                               res_parsed,
    output logic [$clog2(FRAME_DEPTH+1)-1:0]   res_split,
    output logic [$clog2(FRAME_DEPTH+1)-1:0]   res_pay_len
);

    localparam int unsigned IDX_W = $clog2(FRAME_DEPTH + 1);
    localparam int unsigned AW    = $clog2(FRAME_DEPTH);

    top_state_e       state;
    logic             acc, emit_busy, emit_start, store_we;
    logic [IDX_W-1:0] cur_idx, frm_len, dec_split, hdr_len, pay_len;
    logic             dec_parsed;
    logic [AW-1:0]    rd_addr;
    logic [7:0]       rd_data;
    wr_beat_t         hdr_beat, pay_beat;

    assign in_ready   = (state == T_IDLE) || (state == T_RECV);
    assign acc        = in_valid && in_ready && ((state == T_RECV) || in_sof);
    assign emit_start = (state == T_DECIDE);
    assign store_we   = acc && (cur_idx < IDX_W'(FRAME_DEPTH));

    assign hdr_len = (dec_split < frm_len) ? dec_split : frm_len;
    assign pay_len = frm_len - hdr_len;

    hs_proto_parser #(.IDX_W(IDX_W)) u_parse (
        .clk            (clk),
        .rst            (rst),
        .acc            (acc),
        .sof            (in_sof),
        .data           (in_data),
        .cfg_fixed_only (cfg_fixed_only),
        .cfg_fixed_off  (cfg_fixed_off),
        .cur_idx        (cur_idx),
        .frm_len        (frm_len),
        .dec_split      (dec_split),
        .dec_parsed     (dec_parsed)
    );

    hs_frame_store #(.DEPTH(FRAME_DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (AW'(cur_idx)),
        .wdata (in_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    hs_line_emitter #(.IDX_W(IDX_W), .AW(AW), .LINE_BYTES(LINE_BYTES)) u_emit (
        .clk      (clk),
        .rst      (rst),
        .start    (emit_start),
        .hdr_len  (hdr_len),
        .pay_len  (pay_len),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .hdr_beat (hdr_beat),
        .pay_beat (pay_beat),
        .busy     (emit_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= T_IDLE;
            res_valid   <= 1'b0;
            res_parsed  <= 1'b0;
            res_split   <= '0;
            res_pay_len <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                T_IDLE:   if (acc) state <= in_eof ? T_DECIDE : T_RECV;
                T_RECV:   if (acc && in_eof) state <= T_DECIDE;
                T_DECIDE: begin
                    res_valid   <= 1'b1;
                    res_parsed  <= dec_parsed;
                    res_split   <= dec_split;
                    res_pay_len <= pay_len;
                    state       <= T_EMIT;
                end
                T_EMIT:   if (!emit_busy) state <= T_IDLE;
                default:  state <= T_IDLE;
            endcase
        end
    end

    assign hdr_valid = hdr_beat.valid;
    assign hdr_data  = hdr_beat.data;
    assign hdr_pad   = hdr_beat.pad;
    assign hdr_last  = hdr_beat.last;
    assign pay_valid = pay_beat.valid;
    assign pay_data  = pay_beat.data;
    assign pay_pad   = pay_beat.pad;
    assign pay_last  = pay_beat.last;

    AST_NOT_READY_WHILE_EMIT: assert property (@(posedge clk) disable iff (rst)
        emit_busy |-> !in_ready); // R1

    AST_RESULT_BEFORE_WRITES: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (!hdr_valid && !pay_valid)); // R10

    AST_RESULT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R10

    AST_SHORT_FRAME_NO_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_split >= frm_len) |-> (res_pay_len == '0)); // R9

endmodule

// File: tb/sim_rx_hdr_split.sv
`timescale 1ns/1ps
module sim_rx_hdr_split;

    localparam int DEPTH = 256;
    localparam int IW    = $clog2(DEPTH + 1);
    localparam int LINE  = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_fixed_only = 1'b0;
    logic [IW-1:0] cfg_fixed_off = '0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic          hdr_valid, hdr_pad, hdr_last, pay_valid, pay_pad, pay_last;
    logic [7:0]    hdr_data, pay_data;
    logic          res_valid, res_parsed;
    logic [IW-1:0] res_split, res_pay_len;

    always #2.5 clk = ~clk;

    rx_hdr_split #(.FRAME_DEPTH(DEPTH), .LINE_BYTES(LINE)) u0 (
        .clk(clk), .rst(rst), .cfg_fixed_only(cfg_fixed_only), .cfg_fixed_off(cfg_fixed_off),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .in_ready(in_ready),
        .hdr_valid(hdr_valid), .hdr_data(hdr_data), .hdr_pad(hdr_pad), .hdr_last(hdr_last),
        .pay_valid(pay_valid), .pay_data(pay_data), .pay_pad(pay_pad), .pay_last(pay_last),
        .res_valid(res_valid), .res_parsed(res_parsed), .res_split(res_split),
        .res_pay_len(res_pay_len)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [7:0] fr [DEPTH];
    int         fr_len;

    logic [9:0] hq[$];
    logic [9:0] pq[$];
    int         res_cnt;
    bit         beat_before_res, order_bad;
    logic       got_parsed;
    int         got_split, got_pay;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Collect outputs away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                res_cnt++;
                got_parsed = res_parsed;
                got_split  = int'(res_split);
                got_pay    = int'(res_pay_len);
            end
            if (hdr_valid && pay_valid) order_bad = 1'b1;
            if (hdr_valid) begin
                if (res_cnt == 0) beat_before_res = 1'b1;
                if (pq.size() > 0) order_bad = 1'b1;
                hq.push_back({hdr_last, hdr_pad, hdr_data});
            end
            if (pay_valid) begin
                if (res_cnt == 0) beat_before_res = 1'b1;
                if (hq.size() > 0 && hq[hq.size()-1][9] == 1'b0) order_bad = 1'b1;
                pq.push_back({pay_last, pay_pad, pay_data});
            end
        end
    end

    // Reference split decision from the requirements
    task automatic model(input bit fo, input int foff, output int sp, output bit par);
        int tcp;
        int d;
        tcp = -1;
        par = 1'b0;
        if (!fo && fr_len > 13) begin
            if ({fr[12], fr[13]} == 16'h0800 && fr_len > 23 && fr[14][7:4] == 4'd4 &&
                fr[14][3:0] >= 4'd5 && fr[23] == 8'd6)
                tcp = 14 + 4 * int'(fr[14][3:0]);
            else if ({fr[12], fr[13]} == 16'h86DD && fr_len > 20 && fr[14][7:4] == 4'd6 &&
                     fr[20] == 8'd6)
                tcp = 54;
            if (tcp >= 0 && fr_len > tcp + 12) begin
                d = int'(fr[tcp+12][7:4]);
                if (d >= 5 && tcp + 4 * d <= fr_len) begin
                    par = 1'b1;
                    sp  = tcp + 4 * d;
                end
            end
        end
        if (!par) sp = foff;
    endtask

    task automatic cmp_stream(input string req, input string what, input bit is_hdr,
                              input int base, input int n);
        int tot;
        int sz;
        int bad;
        logic [9:0] got;
        logic [9:0] exp;
        tot = ((n + LINE - 1) / LINE) * LINE;
        sz  = is_hdr ? hq.size() : pq.size();
        if (sz != tot) begin
            chk(req, {what, " beat count"}, sz, tot);
        end else begin
            bad = -1;
            got = '0;
            exp = '0;
            for (int i = 0; i < tot; i++) begin
                logic [9:0] e;
                logic [9:0] g;
                e = {(i == tot - 1), (i >= n), (i < n) ? fr[base + i] : 8'h00};
                g = is_hdr ? hq[i] : pq[i];
                if (bad < 0 && e != g) begin
                    bad = i;
                    got = g;
                    exp = e;
                end
            end
            chk(req, {what, " beat {last,pad,data}"}, int'(got), int'(exp));
        end
    endtask

    task automatic build(input int kind, input int ihl, input int doff, input int pay);
        int tcp;
        for (int i = 0; i < DEPTH; i++) fr[i] = 8'($urandom);
        tcp = 54;
        case (kind)
            0, 3: begin
                fr[12] = 8'h08; fr[13] = 8'h00;
                fr[14] = {4'd4, 4'(ihl)};
                fr[23] = (kind == 0) ? 8'd6 : 8'd17;
                tcp = 14 + 4 * ihl;
            end
            1: begin
                fr[12] = 8'h86; fr[13] = 8'hDD;
                fr[14] = {4'd6, 4'($urandom)};
                fr[20] = 8'd6;
            end
            default: begin
                fr[12] = 8'h88; fr[13] = 8'hB5;
            end
        endcase
        fr[tcp+12] = {4'(doff), 4'($urandom)};
        fr_len = tcp + 4 * doff + pay;
    endtask

    task automatic run_frame(input string tag, input bit fo, input int foff,
                             input bit junk, input bit twiddle);
        int  sp;
        bit  par;
        int  h;
        string sreq;
        hq.delete();
        pq.delete();
        res_cnt = 0;
        beat_before_res = 1'b0;
        order_bad = 1'b0;
        @(negedge clk);
        cfg_fixed_only = fo;
        cfg_fixed_off  = IW'(foff);
        if (junk) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = 8'($urandom);
            end
        end
        for (int i = 0; i < fr_len; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == fr_len - 1);
            in_data  = fr[i];
            if (twiddle && i == 2) begin
                cfg_fixed_only = ~fo;
                cfg_fixed_off  = IW'(foff + 37);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        while (!in_ready) @(negedge clk);
        repeat (3) @(negedge clk);

        model(fo, foff, sp, par);
        h = (sp < fr_len) ? sp : fr_len;
        sreq = (sp > fr_len) ? "R9" : "R8";
        chk("R10", {tag, " result pulses"}, res_cnt, 1);
        chk("R10", {tag, " beat before result"}, int'(beat_before_res), 0);
        chk(tag, "split offset", got_split, sp);
        chk(tag, "parsed flag", int'(got_parsed), int'(par));
        chk(sreq, {tag, " payload length"}, got_pay, fr_len - h);
        cmp_stream("R7", {tag, " header"}, 1'b1, 0, h);
        cmp_stream("R8", {tag, " payload"}, 1'b0, h, fr_len - h);
        chk("R12", {tag, " stream order"}, int'(order_bad), 0);
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'd7315);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", int'(in_ready), 1);
        chk("R7", "hdr_valid after reset", int'(hdr_valid), 0);
        chk("R8", "pay_valid after reset", int'(pay_valid), 0);
        chk("R10", "res_valid after reset", int'(res_valid), 0);

        // IPv6 modal layout: split 86
        build(1, 0, 8, 100);  run_frame("R3", 1'b0, 40, 1'b0, 1'b0);
        // IPv4 minimum headers, empty payload: split 54
        build(0, 5, 5, 0);    run_frame("R2", 1'b0, 40, 1'b0, 1'b0);
        // IPv4 largest headers: split 134
        build(0, 15, 15, 30); run_frame("R2", 1'b0, 40, 1'b0, 1'b0);
        // Unknown ethertype falls back
        build(2, 0, 8, 50);   run_frame("R5", 1'b0, 40, 1'b0, 1'b0);
        // Non-TCP protocol falls back
        build(3, 5, 5, 20);   run_frame("R5", 1'b0, 33, 1'b0, 1'b0);
        // Data offset below minimum
        build(1, 0, 4, 40);   run_frame("R4", 1'b0, 21, 1'b0, 1'b0);
        // Truncated frame, fixed offset beyond its end
        build(1, 0, 8, 0);    fr_len = 70;
        run_frame("R9", 1'b0, 100, 1'b0, 1'b0);
        // Fixed-only mode on a valid frame, split one full line
        build(1, 0, 8, 60);   run_frame("R6", 1'b1, 64, 1'b0, 1'b0);
        // Configuration changed inside the frame
        build(1, 0, 8, 25);   run_frame("R11", 1'b0, 40, 1'b0, 1'b1);
        // Stray bytes before start marker
        build(0, 6, 7, 45);   run_frame("R1", 1'b0, 40, 1'b1, 1'b0);
        // Zero fixed offset: header stream empty
        build(2, 0, 8, 26);   run_frame("R5", 1'b0, 0, 1'b0, 1'b0);
        // Single-byte frame
        build(2, 0, 8, 0);    fr_len = 1;
        run_frame("R9", 1'b0, 10, 1'b0, 1'b0);
        // Frame ends before data-offset byte
        build(0, 5, 5, 0);    fr_len = 40;
        run_frame("R5", 1'b0, 14, 1'b0, 1'b0);

        for (int k = 0; k < 60; k++) begin
            int  kind;
            bit  fo;
            string tag;
            kind = int'($urandom_range(3, 0));
            fo   = ($urandom_range(7, 0) == 0);
            build(kind, int'($urandom_range(15, 5)), int'($urandom_range(15, 3)),
                  int'($urandom_range(60, 0)));
            if ($urandom_range(5, 0) == 0) fr_len = int'($urandom_range(fr_len, 1));
            tag = fo ? "R6" : (kind == 0) ? "R2" : (kind == 1) ? "R3" : "R5";
            run_frame(tag, fo, int'($urandom_range(150, 0)), 1'b0, 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule